// File: doc/BRIEF.md
# Four-Mode Observation and Signature Register

This block is an n-bit register that serves four roles, picked by a two-bit mode input. It can be an ordinary parallel-load pipeline register in functional operation, or a serial scan chain stage. It can clear itself in a single clock. It can also act as a multiple-input signature register that compresses a stream of parallel words into a signature. If the parallel word is held constant in signature mode, the register steps through a maximal-length pseudo-random sequence and can drive test patterns.

Every bit is one slice. The slice takes the parallel input bit gated by the upper mode bit and XORs it with the bit before it. The lower mode bit enables or blocks that chaining. For bit 0, a multiplexer chooses between the serial input, used for shifting, and the XOR of the tapped bits, used for signature mode. Test stages are built by placing several of these registers around blocks of logic, so that one register generates stimulus and another compacts the responses.

Top module: `obs_reg4`

## Requirements
- R1: With the default reset variant, driving rst_n low clears q_o to all zeros at once, without waiting for a clock edge. The register stays at zero while rst_n is low.
- R2: Mode 2'b00 (shift) moves the register up by one bit on each rising edge. The new q_o[0] is scan_i and the new q_o[i] is the old q_o[i-1]. par_i has no effect.
- R3: Mode 2'b01 (clear) sets q_o to all zeros on the next rising edge, whatever the values on par_i and scan_i.
- R4: Mode 2'b10 (signature) gives a new q_o[i] of par_i[i] XOR old q_o[i-1] for i>0. The new q_o[0] is par_i[0] XOR the feedback bit. The feedback bit is the XOR of the old q_o bits selected by the TAPS mask. scan_i has no effect.
- R5: In signature mode with par_i held at zero, a nonzero state never becomes zero. With the default TAPS of 8'hB8 (x^8+x^6+x^5+x^4+1, feedback from bits 7,5,4,3), a state of 8'h01 comes back to itself after exactly 255 edges.
- R6: Mode 2'b11 (load) copies par_i into q_o on the next rising edge. scan_i has no effect.
- R7: scan_o always equals q_o[W-1].
- R8: A new mode value acts at the first rising edge after it is applied. That edge uses the new mode's rule on the state the previous mode left, and no cycle is lost or inserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Global reset, active low |
| mode_i | input | 2 | 00 shift, 01 clear, 10 signature, 11 load |
| par_i | input | W | Parallel data input |
| scan_i | input | 1 | Serial input to bit 0 |
| scan_o | output | 1 | Serial output, the top bit |
| q_o | output | W | Register contents |

## Verification
A table of vectors goes through all four modes with alternating, walking-one, all-ones and zero parallel words. A reference model in the bench gives the expected value at every step, so the checks can tell apart the slice gating, the chaining enable and the first-stage multiplexer. Signature mode is checked with zero input, which isolates the feedback taps, and with nonzero input, which shows that the input word is folded in. The zero-input run continues for a full period to confirm that the sequence has maximal length. Directed cases cover an asynchronous reset in the middle of a run, clearing while the inputs are busy, and switching straight from load to shift. These show that the state carries across a mode change.

// File: rtl/obs_reg4_pkg.sv
package obs_reg4_pkg;
   typedef enum logic [1:0] {
      MD_SHIFT = 2'b00,
      MD_CLEAR = 2'b01,
      MD_SIG   = 2'b10,
      MD_LOAD  = 2'b11
   } obs_mode_e;

   typedef struct packed {
      logic gate_par;   // let par_i into the slice XOR
      logic chain_en;   // let previous bit into the slice XOR
      logic head_fb;    // bit 0 takes feedback instead of scan_i
   } obs_ctl_t;
endpackage

// File: rtl/obs_ctrl.sv
module obs_ctrl
   import obs_reg4_pkg::*;
(
   input  logic [1:0] mode_i,
   output obs_ctl_t   ctl_o
);
   always_comb begin
      ctl_o.gate_par = mode_i[1];
      ctl_o.chain_en = ~mode_i[0];
      ctl_o.head_fb  = mode_i[1];
   end
endmodule

// File: rtl/obs_fb.sv
module obs_fb #(
   parameter int          W    = 8,
   parameter logic [W-1:0] TAPS = 8'hB8
) (
   input  logic [W-1:0] q_i,
   output logic         fb_o
);
   logic [W-1:0] tapped;

   generate
      for (genvar k = 0; k < W; k++) begin : g_tap
         if (TAPS[k]) begin : g_on
            assign tapped[k] = q_i[k];
         end else begin : g_off
            assign tapped[k] = 1'b0;
         end
      end
   endgenerate

   assign fb_o = ^tapped;
endmodule

// File: rtl/obs_slice.sv
module obs_slice #(
   parameter bit RST_ASYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_par,
   input  logic chain_en,
   input  logic par_bit,
   input  logic prev_bit,
   output logic q_bit
);
   logic d_bit;

   assign d_bit = (gate_par & par_bit) ^ (chain_en & prev_bit);

   generate
      if (RST_ASYNC) begin : g_arst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_bit <= 1'b0;
            else        q_bit <= d_bit;
         end
      end else begin : g_srst
         always_ff @(posedge clk) begin
            if (!rst_n) q_bit <= 1'b0;
            else        q_bit <= d_bit;
         end
      end
   endgenerate
endmodule

// File: rtl/obs_reg4.sv
module obs_reg4
   import obs_reg4_pkg::*;
#(
   parameter int           W         = 8,
   parameter logic [W-1:0] TAPS      = 8'hB8,
   parameter bit           RST_ASYNC = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   mode_i,
   input  logic [W-1:0] par_i,
   input  logic         scan_i,
   output logic         scan_o,
   output logic [W-1:0] q_o
);
   localparam int TOP = W - 1;

   generate
      if (W < 2) begin : g_bad_w
         $error("obs_reg4: W must be at least 2");
      end
      if (TAPS[TOP] != 1'b1) begin : g_bad_taps
         $error("obs_reg4: TAPS must include the top bit");
      end
   endgenerate

   obs_ctl_t     ctl;
   logic         fb;
   logic         head_in;
   logic [W-1:0] prev_vec;

   obs_ctrl u_ctrl (
      .mode_i (mode_i),
      .ctl_o  (ctl)
   );

   obs_fb #(.W(W), .TAPS(TAPS)) u_fb (
      .q_i  (q_o),
      .fb_o (fb)
   );

   assign head_in  = ctl.head_fb ? fb : scan_i;
   assign prev_vec = {q_o[TOP-1:0], head_in};

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         obs_slice #(.RST_ASYNC(RST_ASYNC)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .gate_par (ctl.gate_par),
            .chain_en (ctl.chain_en),
            .par_bit  (par_i[i]),
            .prev_bit (prev_vec[i]),
            .q_bit    (q_o[i])
         );
      end
   endgenerate

   assign scan_o = q_o[TOP];

   // R2
   shift_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_SHIFT) |=> (q_o == {$past(q_o[TOP-1:0]), $past(scan_i)}));

   // R3
   clear_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_CLEAR) |=> (q_o == '0));

   // R6
   load_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_LOAD) |=> (q_o == $past(par_i)));

   // R4
   sig_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_SIG) |=>
         (q_o[TOP:1] == ($past(par_i[TOP:1]) ^ $past(q_o[TOP-1:0]))));

   // R5
   sig_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_SIG && par_i == '0 && q_o != '0) |=> (q_o != '0));

   // R7
   scan_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_o == q_o[TOP]);
endmodule

// File: tb/obs_reg4_bench.sv
module obs_reg4_bench;
   localparam int W = 8;
   localparam logic [W-1:0] TAPS = 8'hB8;

   typedef struct packed {
      logic [1:0]   mode;
      logic [W-1:0] par;
      logic         scan;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{2'b11, 8'hA5, 1'b0},
      '{2'b00, 8'hFF, 1'b1},
      '{2'b00, 8'h00, 1'b0},
      '{2'b00, 8'h3C, 1'b1},
      '{2'b10, 8'h00, 1'b1},
      '{2'b10, 8'h00, 1'b0},
      '{2'b10, 8'h01, 1'b0},
      '{2'b10, 8'h80, 1'b1},
      '{2'b10, 8'hFF, 1'b0},
      '{2'b01, 8'hFF, 1'b1},
      '{2'b11, 8'h80, 1'b1},
      '{2'b00, 8'h55, 1'b0},
      '{2'b10, 8'hAA, 1'b1},
      '{2'b11, 8'h0F, 1'b0},
      '{2'b10, 8'h0F, 1'b0},
      '{2'b01, 8'h00, 1'b0}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode = 2'b11;
   logic [W-1:0] par = '0;
   logic         scan = 1'b0;
   logic         scan_o;
   logic [W-1:0] q;

   int total = 0;
   int bad = 0;
   logic [W-1:0] exp_q = '0;

   always #2 clk = ~clk;

   obs_reg4 #(.W(W), .TAPS(TAPS)) u_obs_reg4 (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode),
      .par_i  (par),
      .scan_i (scan),
      .scan_o (scan_o),
      .q_o    (q)
   );

   function automatic logic [W-1:0] model(input logic [1:0] m, input logic [W-1:0] z,
                                          input logic s, input logic [W-1:0] cur);
      logic f;
      f = ^(cur & TAPS);
      case (m)
         2'b00:   model = {cur[W-2:0], s};
         2'b01:   model = '0;
         2'b10:   model = z ^ {cur[W-2:0], f};
         default: model = z;
      endcase
   endfunction

   function automatic string tag(input logic [1:0] m);
      case (m)
         2'b00:   tag = "R2";
         2'b01:   tag = "R3";
         2'b10:   tag = "R4";
         default: tag = "R6";
      endcase
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, act, expv);
      end
   endtask

   task automatic step(input logic [1:0] m, input logic [W-1:0] z, input logic s);
      @(negedge clk);
      mode = m; par = z; scan = s;
      @(posedge clk);
      #1;
      exp_q = model(m, z, s, exp_q);
   endtask

   initial begin : watchdog
      #400000;
      bad++; total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int period;
      logic seen_zero;
      // R1 reset state
      #5;
      check("R1", q, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // vector table walk, R8: each entry changes mode back to back
      foreach (VECS[k]) begin
         step(VECS[k].mode, VECS[k].par, VECS[k].scan);
         check(tag(VECS[k].mode), q, exp_q);
         check("R7", {7'd0, scan_o}, {7'd0, q[W-1]});
      end

      // R8: load then shift on the next edge
      step(2'b11, 8'hA5, 1'b0);
      step(2'b00, 8'h00, 1'b1);
      check("R8", q, 8'h4B);

      // R2: par_i ignored in shift
      step(2'b00, 8'hFF, 1'b0);
      check("R2", q, 8'h96);

      // R6: scan ignored in load
      step(2'b11, 8'h3C, 1'b1);
      check("R6", q, 8'h3C);

      // R4: first signature step from 8'h81, feedback = q7^q5^q4^q3 = 1
      step(2'b11, 8'h81, 1'b0);
      step(2'b10, 8'h00, 1'b0);
      check("R4", q, 8'h03);

      // R5: full period from 8'h01
      step(2'b11, 8'h01, 1'b0);
      period = 0;
      seen_zero = 1'b0;
      for (int n = 0; n < 300; n++) begin
         step(2'b10, 8'h00, 1'b0);
         period++;
         if (q == '0) seen_zero = 1'b1;
         if (q == 8'h01) break;
      end
      check("R5", period[W-1:0], 8'd255);
      check("R5", {7'd0, seen_zero}, 8'h00);
      check("R5", q, exp_q);

      // R3: clear with busy inputs
      step(2'b11, 8'hE7, 1'b0);
      step(2'b01, 8'hFF, 1'b1);
      check("R3", q, 8'h00);

      // R1: async reset mid-run, no clock edge needed
      step(2'b11, 8'h5A, 1'b0);
      @(negedge clk);
      #0.5 rst_n = 1'b0;
      #0.5;
      check("R1", q, 8'h00);
      @(posedge clk);
      #1;
      check("R1", q, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      exp_q = '0;
      step(2'b11, 8'hC3, 1'b0);
      check("R6", q, 8'hC3);
      check("R7", {7'd0, scan_o}, 8'h01);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule